// File: doc/BRIEF.md
# Framed Serial DAC Input Register

This block is the digital front end of a 10-bit voltage-output converter that takes its settings over a three-wire serial link. It runs on a fast system clock and oversamples the serial clock, an active-low frame sync and the data line. Each line passes through a two-flop synchronizer, and the block detects serial-clock falling edges by comparing the synchronized level with its value one cycle earlier.

A frame begins when sync goes low. Each following falling edge shifts one data bit, most significant first, into a 16-bit word. On exactly the sixteenth falling edge the block loads a 10-bit code and a 2-bit power-down mode into held output registers and pulses an update strobe for one system cycle. If sync returns high before that edge, the partial frame is dropped and the outputs keep their values. Once a frame has committed, more serial-clock edges do nothing until sync goes high and then low again. After reset the held code is zero and stays at zero until the first complete frame. The system clock must run at least four times faster than the serial clock.

Top module: `dacSerialFrontEnd`

## Requirements
- R1: After reset the held code is 0, the mode is 0 (normal), the valid flag is 0 and the update strobe is 0.
- R2: A complete frame of 16 falling edges, sent most significant bit first, loads word bits [11:2] into the held code. Bit 11 is the code MSB.
- R3: The same frame loads word bits [13:12] into the mode. 00 is normal operation, and 01, 10 and 11 are three distinct power-down types. A complete frame carrying 00 returns the block to normal.
- R4: Word bits [15:14] and [1:0] have no effect on any output.
- R5: If sync returns high after fewer than 16 falling edges, the frame is discarded. The code, the mode and the valid flag are unchanged, and no update strobe is raised.
- R6: Each complete frame raises the update strobe for exactly one system cycle. The code and the mode change only in a cycle where the strobe is high.
- R7: After the sixteenth falling edge, further serial-clock edges are ignored until sync has gone high and then low again.
- R8: The valid flag rises together with the first update strobe and then stays high until reset.
- R9: A frame that starts after an aborted frame counts its edges from zero and commits normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock, asynchronous to clk |
| syncNIn | input | 1 | Active-low frame sync, asynchronous |
| dinIn | input | 1 | Serial data, asynchronous |
| dacCode | output | 10 | Held converter code |
| pdMode | output | 2 | Held power-down mode, 00 = normal |
| updateStb | output | 1 | One-cycle pulse on each commit |
| codeValid | output | 1 | High once any complete frame has committed |

## Verification
A wrong bit counter or a wrong frame state shows at the ports within one frame. The held code and mode either fail to change after the sixteenth edge, or they change after an aborted frame or after extra edges. A wrong pulse count also appears a few system cycles after the sixteenth edge. A wrong field slice shows up as a mismatch on the next committed word, and the test sweep changes the pad bits and every mode value to catch it. A stuck valid flag or a wide strobe shows on the first commit after reset.

// File: rtl/dacFePkg.sv
package dacFePkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic shift;   // take one serial bit
    logic commit;  // load held registers from the completed word
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } frameState_e;

endpackage

// File: rtl/lineSync.sv
module lineSync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= RESET_VAL;
      else if (s == 0) stageQ[s] <= asyncIn;
      else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/dacFrameCtrl.sv
module dacFrameCtrl
  import dacFePkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkS,
  input  logic       syncNS,
  output ctlStrobe_t strobe
);

  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  frameState_e state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic sclkPrev;
  logic fallEdge;

  assign fallEdge = sclkPrev & ~sclkS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      sclkPrev <= 1'b1;
    end else begin
      state    <= stateNext;
      bitCnt   <= bitCntNext;
      sclkPrev <= sclkS;
    end
  end

  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    strobe     = '0;
    unique case (state)
      ST_IDLE: begin
        if (!syncNS) begin
          stateNext  = ST_SHIFT;
          bitCntNext = '0;
          if (fallEdge) begin
            strobe.shift = 1'b1;
            bitCntNext   = CNT_W'(1);
          end
        end
      end
      ST_SHIFT: begin
        if (syncNS) begin
          stateNext = ST_IDLE;          // early end: drop the frame
        end else if (fallEdge) begin
          strobe.shift = 1'b1;
          bitCntNext   = bitCnt + CNT_W'(1);
          if (bitCnt == LAST_IDX) begin
            strobe.commit = 1'b1;
            stateNext     = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        if (syncNS) stateNext = ST_IDLE; // wait for a fresh frame
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dacFrameData.sv
module dacFrameData
  import dacFePkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CODE_W = 10,
  parameter int MODE_W = 2,
  parameter int CODE_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dinS,
  input  ctlStrobe_t        strobe,
  output logic [CODE_W-1:0] dacCode,
  output logic [MODE_W-1:0] pdMode,
  output logic              updateStb,
  output logic              codeValid
);

  localparam int MODE_LSB = CODE_LSB + CODE_W;

  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] nextWord;

  assign nextWord = {shiftReg[FRAME_W-2:0], dinS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shift) shiftReg <= nextWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode   <= '0;
      pdMode    <= '0;
      updateStb <= 1'b0;
      codeValid <= 1'b0;
    end else begin
      updateStb <= strobe.commit;
      if (strobe.commit) begin
        dacCode   <= nextWord[MODE_LSB-1:CODE_LSB];
        pdMode    <= nextWord[MODE_LSB+MODE_W-1:MODE_LSB];
        codeValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dacSerialFrontEnd.sv
module dacSerialFrontEnd
  import dacFePkg::*;
#(
  parameter int CODE_W = 10,
  parameter int MODE_W = 2,
  parameter int FRAME_W = 16,
  parameter int LEAD_PAD = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              syncNIn,
  input  logic              dinIn,
  output logic [CODE_W-1:0] dacCode,
  output logic [MODE_W-1:0] pdMode,
  output logic              updateStb,
  output logic              codeValid
);

  localparam int CODE_LSB = FRAME_W - LEAD_PAD - MODE_W - CODE_W;

  logic [2:0] rawLines, syncLines;
  ctlStrobe_t strobe;

  assign rawLines = {dinIn, syncNIn, sclkIn};

  // idle levels: data 0, sync high, serial clock high
  lineSync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b011)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(rawLines), .syncOut(syncLines)
  );

  dacFrameCtrl #(.FRAME_W(FRAME_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclkS(syncLines[0]), .syncNS(syncLines[1]),
    .strobe(strobe)
  );

  dacFrameData #(
    .FRAME_W(FRAME_W), .CODE_W(CODE_W), .MODE_W(MODE_W), .CODE_LSB(CODE_LSB)
  ) uData (
    .clk(clk), .rstN(rstN), .dinS(syncLines[2]), .strobe(strobe),
    .dacCode(dacCode), .pdMode(pdMode), .updateStb(updateStb),
    .codeValid(codeValid)
  );

endmodule

// File: rtl/dacFrontEndChk.sv
module dacFrontEndChk #(
  parameter int CODE_W = 10,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] dacCode,
  input logic [MODE_W-1:0] pdMode,
  input logic              updateStb,
  input logic              codeValid
);

  AST_ZERO_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !codeValid |-> (dacCode == '0 && pdMode == '0)); // R1

  AST_CODE_MOVES_ON_STB: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacCode) |-> updateStb); // R6

  AST_MODE_MOVES_ON_STB: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pdMode) |-> updateStb); // R6

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |=> !updateStb); // R6

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> codeValid); // R8

  AST_VALID_RISE_STB: assert property (@(posedge clk) disable iff (!rstN)
    $rose(codeValid) |-> updateStb); // R8

  AST_STB_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |-> codeValid); // R8

endmodule

bind dacSerialFrontEnd dacFrontEndChk #(.CODE_W(CODE_W), .MODE_W(MODE_W)) uChk (
  .clk(clk), .rstN(rstN), .dacCode(dacCode), .pdMode(pdMode),
  .updateStb(updateStb), .codeValid(codeValid)
);

// File: tb/dacSerialFrontEnd_test.sv
module dacSerialFrontEnd_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b1;
  logic syncN = 1'b1;
  logic din = 1'b0;
  logic [9:0] dacCode;
  logic [1:0] pdMode;
  logic updateStb, codeValid;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dacSerialFrontEnd uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .syncNIn(syncN), .dinIn(din),
    .dacCode(dacCode), .pdMode(pdMode), .updateStb(updateStb),
    .codeValid(codeValid)
  );

  // count strobe cycles; a wide strobe counts more than once
  always @(negedge clk) if (rstN && updateStb) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // nFall data edges from word (MSB first), then extra edges of filler data
  task automatic sendFrame(input logic [15:0] word, input int nFall, input int extra);
    syncN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nFall + extra; i++) begin
      din = (i < 16) ? word[15 - i] : i[0];
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (4) @(negedge clk);
    syncN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [15:0] mkWord(input int hi, input int mode, input int code, input int lo);
    return {hi[1:0], mode[1:0], code[9:0], lo[1:0]};
  endfunction

  initial begin
    int expCode, expMode, expPulses;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 code", int'(dacCode), 0);
    chk("R1 mode", int'(pdMode), 0);
    chk("R1 valid", int'(codeValid), 0);
    chk("R1 strobe", int'(updateStb), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R5: abort before first commit keeps reset values
    sendFrame(mkWord(3, 2, 1023, 3), 15, 0);
    chk("R5 code pre-valid", int'(dacCode), 0);
    chk("R5/R8 valid stays 0", int'(codeValid), 0);
    chk("R5 no strobe", pulses, 0);

    // R2 R3 R4 R6 R8 R9: sweep codes, modes and pad bits
    expPulses = 0;
    for (int k = 0; k < 29; k++) begin
      for (int m = 0; m < 4; m++) begin
        int code;
        code = (k == 28) ? 1023 : (k * 37 + m * 5) % 1024;
        sendFrame(mkWord(k + m, m, code, (k >> 2) + m), 16, 0);
        expPulses++;
        chk("R2 code", int'(dacCode), code);
        chk("R3 mode", int'(pdMode), m);
        chk("R4/R6 strobe count", pulses, expPulses);
        chk("R8 valid", int'(codeValid), 1);
      end
    end
    // R3: a mode 00 frame returns to normal (last sweep mode was 3)
    sendFrame(mkWord(1, 0, 512, 2), 16, 0);
    expPulses++;
    chk("R3 back to normal", int'(pdMode), 0);
    chk("R2 code 512", int'(dacCode), 512);
    expCode = 512;
    expMode = 0;

    // R5 R9: every short frame length, each followed by a full frame
    for (int n = 0; n < 16; n++) begin
      sendFrame(mkWord(2, 3, 85 + n, 1), n, 0);
      chk("R5 code after abort", int'(dacCode), expCode);
      chk("R5 mode after abort", int'(pdMode), expMode);
      chk("R5 no strobe", pulses, expPulses);
      expCode = (n * 61 + 7) % 1024;
      expMode = n % 4;
      sendFrame(mkWord(n, expMode, expCode, n + 1), 16, 0);
      expPulses++;
      chk("R9 code after restart", int'(dacCode), expCode);
      chk("R9 mode after restart", int'(pdMode), expMode);
      chk("R6 one strobe", pulses, expPulses);
    end

    // R7: edges beyond the sixteenth are ignored
    for (int x = 1; x < 20; x += 6) begin
      expCode = 300 + x;
      expMode = x % 4;
      sendFrame(mkWord(0, expMode, expCode, 0), 16, x);
      expPulses++;
      chk("R7 code kept", int'(dacCode), expCode);
      chk("R7 mode kept", int'(pdMode), expMode);
      chk("R7 single strobe", pulses, expPulses);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule